// File: doc/BRIEF.md
# I2C Burst-Write Channel Register Front End

This block is a write-only I2C target that sits in front of a 32-channel converter register bank. It samples SCL and SDA on the system clock and finds START and STOP conditions. It shifts in bytes MSB first, checks the device address against two strap inputs, and pulls SDA low to acknowledge. It then turns the pointer and data bytes into single-cycle write strobes. Each strobe carries a channel number, a 2-bit register select and a 14-bit value.

Two framings are accepted. In the three-byte framing, a pointer byte names the channel and two data bytes follow. A pointer of 0xFF sent as the first byte after the address switches the target into a burst framing. In burst framing only data byte pairs follow, and the channel advances by one after every pair. Burst framing ends by itself once the last channel has been written, or at any STOP.

Top module: `i2c_burst_wr`

## Requirements
- R1: After reset, sda_oe_o and wr_o are both low.
- R2: An address byte of 1,0,1,0,1, then dev_sel_i[1], dev_sel_i[0], then R/W=0 is acknowledged. The target holds sda_oe_o high for the whole ninth SCL period. Every later pointer or data byte of that transaction is acknowledged the same way.
- R3: An address byte whose select bits differ from dev_sel_i, or whose R/W bit is 1, gets no acknowledge. All bytes after it, up to the next START, are neither acknowledged nor written.
- R4: In three-byte framing, bits [4:0] of the pointer byte give the channel and bits [7:5] are ignored. In the first data byte, bits [7:6] are the register select and bits [5:0] are value bits 13..8. The second data byte holds value bits 7..0. The next byte is again a pointer.
- R5: wr_o is a one-cycle pulse that follows the falling SCL edge ending the acknowledge of the second data byte. It is never issued before that acknowledge. wr_chan_o, wr_reg_o and wr_data_o are valid while wr_o is high.
- R6: A pointer of 0xFF received as the first byte after the address starts burst framing at channel 0. Each data byte pair then writes the current channel, and the channel increments by one.
- R7: After channel 31 has been written in burst framing, the next byte is taken as a three-byte framing pointer.
- R8: A STOP ends burst framing. The next transaction starts with an address byte followed by a three-byte framing pointer.
- R9: A pointer of 0xFF that is not the first byte after the address is an ordinary pointer to channel 31 and does not start burst framing.
- R10: A repeated START drops any partly received write. The next byte is taken as an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| dev_sel_i | input | 2 | Strapped device-select bits compared with address bits 2:1 |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| wr_o | output | 1 | One-cycle register write strobe |
| wr_chan_o | output | 5 | Channel being written |
| wr_reg_o | output | 2 | Register select within the channel |
| wr_data_o | output | 14 | Value written |

## Verification
A wrong framing state shows up at the very next ninth SCL clock. Either an acknowledge is missing on a byte that should get one, or an acknowledge appears after a rejected address. A wrong channel counter or burst flag shows up on the next write strobe as a wrong channel number. It also shows up as a missing pointer byte after a burst ends at the last channel or at a STOP. The bench sends bursts of full length and of cut-short length, repeated STARTs in the middle of a write, 0xFF in both pointer positions, and rejected addresses. It compares every strobe with a list of expected writes built from the requirements, and it checks the acknowledge on every byte.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam logic [4:0] ADDR_FIX  = 5'b10101;
  localparam logic [7:0] BURST_PTR = 8'hFF;
  localparam int         DATA_W    = 14;
  localparam int         REG_W     = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_MSB,
    ST_LSB
  } wr_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, lvl;
  logic       scl_q, sda_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '1;
      else         ff <= {ff[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = ff[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= lvl[0];
      sda_q <= lvl[1];
    end
  end

  assign scl_o      = lvl[0];
  assign sda_o      = lvl[1];
  assign scl_rise_o = lvl[0] & ~scl_q;
  assign scl_fall_o = ~lvl[0] & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = lvl[0] & scl_q & sda_q & ~lvl[1];
  assign stop_o     = lvl[0] & scl_q & ~sda_q & lvl[1];
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       ack_en_i,
  output logic [7:0] byte_o,
  output logic       byte_rdy_o,
  output logic       ack_done_o,
  output logic       sda_oe_o
);
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic       ack_ph_q, oe_q, rdy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      ack_ph_q <= 1'b0;
      oe_q     <= 1'b0;
      rdy_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      rdy_q  <= 1'b0;
      done_q <= 1'b0;
      if (start_i || stop_i) begin
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
        oe_q     <= 1'b0;
      end else begin
        if (scl_rise_i && cnt_q < 4'd8) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
          rdy_q <= (cnt_q == 4'd7);
        end
        if (scl_fall_i && cnt_q == 4'd8) begin
          if (!ack_ph_q) begin
            ack_ph_q <= 1'b1;
            oe_q     <= ack_en_i;
          end else begin
            ack_ph_q <= 1'b0;
            oe_q     <= 1'b0;
            cnt_q    <= '0;
            done_q   <= oe_q;
          end
        end
      end
    end
  end

  assign byte_o     = sh_q;
  assign byte_rdy_o = rdy_q;
  assign ack_done_o = done_q;
  assign sda_oe_o   = oe_q;

  assert_ack_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_i);
  assert_bitcnt_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd8);
endmodule

// File: rtl/i2c_wr_decoder.sv
module i2c_wr_decoder
  import i2c_wr_pkg::*;
#(
  parameter int N_CH = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_rdy_i,
  input  logic              ack_done_i,
  input  logic [1:0]        dev_sel_i,
  output logic              ack_en_o,
  output logic              wr_o,
  output logic [CH_W-1:0]   wr_chan_o,
  output logic [REG_W-1:0]  wr_reg_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam logic [CH_W-1:0] CH_MAX = CH_W'(N_CH - 1);

  wr_state_e         state_q;
  logic              burst_q, first_q, ack_q, pend_q, wr_q;
  logic [CH_W-1:0]   chan_q, out_chan_q;
  logic [REG_W-1:0]  reg_q, out_reg_q;
  logic [5:0]        hi_q;
  logic [DATA_W-1:0] out_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      burst_q    <= 1'b0;
      first_q    <= 1'b0;
      ack_q      <= 1'b0;
      pend_q     <= 1'b0;
      wr_q       <= 1'b0;
      chan_q     <= '0;
      reg_q      <= '0;
      hi_q       <= '0;
      out_chan_q <= '0;
      out_reg_q  <= '0;
      out_data_q <= '0;
    end else begin
      wr_q <= 1'b0;
      if (start_i || stop_i) begin
        state_q <= start_i ? ST_ADDR : ST_IDLE;
        burst_q <= 1'b0;
        ack_q   <= 1'b0;
        pend_q  <= 1'b0;
      end else begin
        if (ack_done_i && pend_q) begin
          wr_q   <= 1'b1;
          pend_q <= 1'b0;
        end
        if (byte_rdy_i) begin
          ack_q <= 1'b0;
          unique case (state_q)
            ST_ADDR: begin
              if (byte_i[7:3] == ADDR_FIX && byte_i[2:1] == dev_sel_i && !byte_i[0]) begin
                ack_q   <= 1'b1;
                first_q <= 1'b1;
                state_q <= ST_PTR;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_PTR: begin
              ack_q   <= 1'b1;
              first_q <= 1'b0;
              state_q <= ST_MSB;
              if (first_q && byte_i == BURST_PTR) begin
                burst_q <= 1'b1;
                chan_q  <= '0;
              end else begin
                chan_q  <= byte_i[CH_W-1:0];
              end
            end
            ST_MSB: begin
              ack_q   <= 1'b1;
              reg_q   <= byte_i[7:6];
              hi_q    <= byte_i[5:0];
              state_q <= ST_LSB;
            end
            ST_LSB: begin
              ack_q      <= 1'b1;
              out_chan_q <= chan_q;
              out_reg_q  <= reg_q;
              out_data_q <= {hi_q, byte_i};
              pend_q     <= 1'b1;
              if (burst_q && chan_q != CH_MAX) begin
                chan_q  <= chan_q + 1'b1;
                state_q <= ST_MSB;
              end else begin
                burst_q <= 1'b0;
                state_q <= ST_PTR;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign ack_en_o  = ack_q;
  assign wr_o      = wr_q;
  assign wr_chan_o = out_chan_q;
  assign wr_reg_o  = out_reg_q;
  assign wr_data_o = out_data_q;

  assert_burst_end_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(burst_q) |-> ($past(chan_q) == CH_MAX || $past(start_i) || $past(stop_i)));
  assert_stop_clears_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !burst_q);
endmodule

// File: rtl/i2c_burst_wr.sv
module i2c_burst_wr
  import i2c_wr_pkg::*;
#(
  parameter int N_CH        = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        dev_sel_i,
  output logic              sda_oe_o,
  output logic              wr_o,
  output logic [CH_W-1:0]   wr_chan_o,
  output logic [REG_W-1:0]  wr_reg_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic [7:0] rx_byte;
  logic       byte_rdy, ack_done, ack_en;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_bit_engine u_bits (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .ack_en_i(ack_en), .byte_o(rx_byte), .byte_rdy_o(byte_rdy),
    .ack_done_o(ack_done), .sda_oe_o(sda_oe_o)
  );

  i2c_wr_decoder #(.N_CH(N_CH)) u_dec (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop),
    .byte_i(rx_byte), .byte_rdy_i(byte_rdy), .ack_done_i(ack_done),
    .dev_sel_i, .ack_en_o(ack_en), .wr_o, .wr_chan_o, .wr_reg_o, .wr_data_o
  );

  assert_wr_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
  assert_wr_after_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !sda_oe_o);
endmodule

// File: tb/tb_i2c_burst_wr.sv
`timescale 1ns/1ps
module tb_i2c_burst_wr;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] dev_sel = 2'b10;
  logic       sda_oe, wr;
  logic [4:0] wr_chan;
  logic [1:0] wr_reg;
  logic [13:0] wr_data;
  wire        sda_bus = sda_m & ~sda_oe;

  i2c_burst_wr dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .dev_sel_i(dev_sel),
    .sda_oe_o(sda_oe), .wr_o(wr), .wr_chan_o(wr_chan), .wr_reg_o(wr_reg), .wr_data_o(wr_data)
  );

  int checks = 0, errors = 0;
  int got [0:1023];
  int expd [0:1023];
  int n_got = 0, n_exp = 0, n_ver = 0, n_at_ack = 0, pulse_bad = 0;
  logic wr_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n && wr) begin
      if (n_got < 1024) got[n_got] = (int'(wr_chan) << 16) | (int'(wr_reg) << 14) | int'(wr_data);
      n_got++;
      if (wr_prev) pulse_bad++;
    end
    wr_prev = wr;
  end

  function automatic int pack_wr(int ch, int rg, int d);
    return (ch << 16) | (rg << 14) | (d & 16'h3FFF);
  endfunction

  function automatic logic [7:0] addr_byte(logic [1:0] sel, logic rw);
    return {5'b10101, sel, rw};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    n_at_ack = n_got;
    chk((!sda_bus) == exp_ack, req, int'(!sda_bus), int'(exp_ack));
    wq(); scl_m = 1'b0; wq(); wq();
  endtask

  task automatic data_pair(input int ch, input int rg, input int d, input string req);
    int n0;
    n0 = n_got;
    send_byte({rg[1:0], d[13:8]}, 1'b1, req);
    send_byte(d[7:0], 1'b1, req);
    chk(n_at_ack == n0, "R5 no strobe before ack", n_at_ack, n0);
    wq();
    chk(n_got == n0 + 1, "R5 strobe count", n_got, n0 + 1);
    expd[n_exp] = pack_wr(ch, rg, d);
    n_exp++;
  endtask

  task automatic verify(input string req);
    chk(n_got == n_exp, req, n_got, n_exp);
    for (int i = n_ver; i < n_exp; i++) chk(got[i] == expd[i], req, got[i], expd[i]);
    n_ver = n_exp;
  endtask

  task automatic burst_run(input int len, input string req);
    i2c_start();
    send_byte(addr_byte(dev_sel, 1'b0), 1'b1, "R2");
    send_byte(8'hFF, 1'b1, "R6");
    for (int c = 0; c < len; c++) data_pair(c, int'($urandom % 4), int'($urandom % 16384), req);
  endtask

  initial begin
    int unused_seed;
    unused_seed = int'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 sda_oe_o", int'(sda_oe), 0);
    chk(wr == 1'b0, "R1 wr_o", int'(wr), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4: three-byte framing, random pointers with junk upper bits
    i2c_start();
    send_byte(addr_byte(dev_sel, 1'b0), 1'b1, "R2");
    for (int k = 0; k < 6; k++) begin
      int ch = int'($urandom % 32);
      logic [7:0] p = {3'($urandom), 5'(ch)};
      if (k == 0 && p == 8'hFF) p = 8'h7F;
      send_byte(p, 1'b1, "R4");
      data_pair(ch, int'($urandom % 4), int'($urandom % 16384), "R4");
    end
    i2c_stop();
    verify("R4");

    // R3: wrong select bits, then R/W=1
    i2c_start();
    send_byte(addr_byte(dev_sel ^ 2'b01, 1'b0), 1'b0, "R3 bad select");
    send_byte(8'h03, 1'b0, "R3 ignored");
    send_byte(8'h12, 1'b0, "R3 ignored");
    send_byte(8'h34, 1'b0, "R3 ignored");
    i2c_stop();
    i2c_start();
    send_byte(addr_byte(dev_sel, 1'b1), 1'b0, "R3 read");
    send_byte(8'hFF, 1'b0, "R3 ignored");
    send_byte(8'h12, 1'b0, "R3 ignored");
    send_byte(8'h34, 1'b0, "R3 ignored");
    i2c_stop();
    verify("R3 no writes");

    // R6 R7: full burst then a normal pointer
    burst_run(32, "R6");
    send_byte(8'h05, 1'b1, "R7");
    data_pair(5, 2, 14'h2ABC, "R7");
    i2c_stop();
    verify("R7");

    // R8: burst cut short by STOP
    burst_run(3, "R6");
    i2c_stop();
    i2c_start();
    send_byte(addr_byte(dev_sel, 1'b0), 1'b1, "R2");
    send_byte(8'h0A, 1'b1, "R8");
    data_pair(10, 1, 14'h1234, "R8");
    i2c_stop();
    verify("R8");

    // R10: repeated START drops a partial write
    i2c_start();
    send_byte(addr_byte(dev_sel, 1'b0), 1'b1, "R2");
    send_byte(8'h07, 1'b1, "R10");
    send_byte(8'hC5, 1'b1, "R10");
    i2c_start();
    send_byte(addr_byte(dev_sel, 1'b0), 1'b1, "R10 address after Sr");
    send_byte(8'h09, 1'b1, "R10");
    data_pair(9, 3, 14'h3FFF, "R10");
    i2c_stop();
    verify("R10");

    // R9: 0xFF later in a transaction is channel 31
    i2c_start();
    send_byte(addr_byte(dev_sel, 1'b0), 1'b1, "R2");
    send_byte(8'h02, 1'b1, "R9");
    data_pair(2, 0, 14'h0001, "R9");
    send_byte(8'hFF, 1'b1, "R9");
    data_pair(31, 2, 14'h2000, "R9");
    send_byte(8'h04, 1'b1, "R9");
    data_pair(4, 1, 14'h0F0F, "R9");
    i2c_stop();
    verify("R9");

    // random mix
    for (int t = 0; t < 12; t++) begin
      if ($urandom % 2) begin
        burst_run(1 + int'($urandom % 12), "R6 random");
      end else begin
        int nw = 1 + int'($urandom % 4);
        i2c_start();
        send_byte(addr_byte(dev_sel, 1'b0), 1'b1, "R2");
        for (int k = 0; k < nw; k++) begin
          int ch = int'($urandom % 31);
          send_byte(8'(ch), 1'b1, "R4 random");
          data_pair(ch, int'($urandom % 4), int'($urandom % 16384), "R4 random");
        end
      end
      i2c_stop();
      verify("R4/R6 random");
    end

    chk(pulse_bad == 0, "R5 single-cycle strobe", pulse_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule